// File: doc/BRIEF.md
# Daisy-Chain Slot Refresh Controller

This controller services a long serial chain of identical small user designs, each with one 8-bit input lane and one 8-bit output lane. A 9-bit slot number picks one design. Every refresh writes the chosen input byte into that design's cells, strobes a latch so the design sees it, and loads the design's outputs back into the chain. It then shifts the whole chain out and keeps only the chosen slot's byte. Refreshes repeat back to back with no request needed, and each one ends with a single-cycle completion pulse.

The controller drives four lines into the chain: shift clock, shift data, a load-select that makes the cells capture design outputs instead of shifting, and a latch strobe. It reads the data and clock that leave the far end of the chain. After the latch strobe it waits a number of settle cycles before capturing. That count has a default, and it can be replaced when the controller comes out of reset.

Top module: `scan_chain_ctrl`

## Requirements
- R1: While `rst_n` is low, `scan_clk`, `scan_dout`, `scan_sel`, `scan_latch` and `ready` are 0 and `out_byte` is 0.
- R2: Each chain bit takes two `clk` cycles, `scan_clk` low and then high. A refresh has 16*NUM_SLOTS high cycles of `scan_clk` with `scan_sel` low: 8*NUM_SLOTS while loading and 8*NUM_SLOTS while unloading.
- R3: Chain cell 0 is the first cell after `scan_dout`. After the latch strobe, cell 8*s+j holds bit j of the snapshot `in_byte`, where s is the snapshot slot. Every other cell in the chain holds 0.
- R4: Capture holds `scan_sel` high for exactly two cycles, starting with `scan_clk` low, so the chain sees exactly one rising edge while `scan_sel` is high.
- R5: `ready` is high for exactly one cycle per refresh. In that cycle `out_byte` already carries the selected slot's output byte, with bit j taken from chain cell 8*s+j. `out_byte` changes in no other cycle.
- R6: Refreshes restart on their own. Two consecutive `ready` pulses are 32*NUM_SLOTS + 5 + W cycles apart, where W is the settle count.
- R7: If `drv_sel` is not 2'b11 in the last cycle of internal reset, W equals DEFAULT_WAIT.
- R8: If `drv_sel` is 2'b11 in the last cycle of internal reset, W is the value of `in_byte` in that cycle. W = 0 removes the settle phase.
- R9: `sel_slot` and `in_byte` are sampled once at the start of each refresh. Changes made while a refresh runs appear only in the next refresh's result.
- R10: If the slot number is NUM_SLOTS or higher, no cell is loaded with the input byte and `out_byte` becomes 0 at the next `ready`.
- R11: A returned bit is accepted only while `ret_clk` is low. If `ret_clk` stays high for a whole refresh, that refresh yields `out_byte` = 0.
- R12: `scan_latch` is high for exactly one cycle per refresh. In that cycle `scan_clk` and `scan_sel` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| drv_sel | input | 2 | Both bits high at reset release means take the settle count from `in_byte` |
| sel_slot | input | SEL_W | Slot number to refresh |
| in_byte | input | 8 | Byte to write into the selected slot; also the settle count at reset |
| ret_clk | input | 1 | Shift clock as it leaves the far end of the chain |
| ret_data | input | 1 | Serial data leaving the far end of the chain |
| scan_clk | output | 1 | Shift clock into the chain |
| scan_dout | output | 1 | Serial data into the chain |
| scan_sel | output | 1 | High: cells load design outputs on the next shift clock edge |
| scan_latch | output | 1 | Strobe that moves shifted bits into the designs' inputs |
| ready | output | 1 | One-cycle pulse at the end of each refresh |
| out_byte | output | 8 | Output byte of the selected slot from the last refresh |

## Verification
The hardest case to reach from the ports is the settle-count override. It is visible only in the narrow window just before internal reset releases, and it shows up only as a change in refresh period. The stimulus holds `drv_sel` and `in_byte` steady across reset release with several different values, including zero. It then measures the spacing between `ready` pulses. The other hard case is a slot number that changes in the middle of a refresh. That is reached by changing inputs a fixed number of cycles after a `ready` pulse and checking two results in a row.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;
  // Width of one slot's input and output lane on the chain.
  localparam int LANE_W     = 8;
  localparam int LANE_IDX_W = $clog2(LANE_W);

  typedef enum logic [2:0] {
    ST_IDLE,    // take a snapshot of the slot number and the byte
    ST_LOAD,    // shift the whole chain, byte placed at the slot
    ST_STROBE,  // latch strobe
    ST_SETTLE,  // settle cycles
    ST_GRAB,    // one shift clock with load-select high
    ST_DRAIN,   // shift the whole chain out, keep the slot's byte
    ST_DONE     // completion pulse
  } scan_state_e;
endpackage

// File: rtl/scan_chain_rst_sync.sv
module scan_chain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n,
  output logic load_win
);
  logic [STAGES-1:0] stage_q;
  logic              shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      shadow_q <= 1'b0;
    end else begin
      stage_q  <= {stage_q[STAGES-2:0], 1'b1};
      shadow_q <= stage_q[STAGES-2];
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];
  // High only in the last cycle before internal reset releases.
  assign load_win   = stage_q[STAGES-2] & ~shadow_q;
endmodule

// File: rtl/scan_chain_fsm.sv
module scan_chain_fsm
  import scan_chain_pkg::*;
#(
  parameter int NUM_SLOTS = 500,
  parameter int CNT_W     = $clog2(LANE_W * NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] wait_len,
  output scan_state_e       state,
  output logic [CNT_W-1:0]  pos,
  output logic              phase
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANE_W * NUM_SLOTS - 1);

  scan_state_e       state_q, state_d;
  logic [CNT_W-1:0]  pos_q, pos_d;
  logic              ph_q, ph_d;
  logic [LANE_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    ph_d    = ph_q;
    wcnt_d  = wcnt_q;
    case (state_q)
      ST_IDLE: begin
        state_d = ST_LOAD;
        pos_d   = LAST;
        ph_d    = 1'b0;
      end
      ST_LOAD, ST_DRAIN: begin
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (pos_q == '0) state_d = (state_q == ST_LOAD) ? ST_STROBE : ST_DONE;
          else             pos_d   = pos_q - 1'b1;
        end
      end
      ST_STROBE: begin
        ph_d = 1'b0;
        if (wait_len == '0) begin
          state_d = ST_GRAB;
        end else begin
          state_d = ST_SETTLE;
          wcnt_d  = wait_len - 1'b1;
        end
      end
      ST_SETTLE: begin
        if (wcnt_q == '0) state_d = ST_GRAB;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      ST_GRAB: begin
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d    = 1'b0;
          pos_d   = LAST;
          state_d = ST_DRAIN;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      ph_q    <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      ph_q    <= ph_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign state = state_q;
  assign pos   = pos_q;
  assign phase = ph_q;
endmodule

// File: rtl/scan_chain_bytepath.sv
module scan_chain_bytepath
  import scan_chain_pkg::*;
#(
  parameter int SEL_W = 9,
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scan_state_e       state,
  input  logic [CNT_W-1:0]  pos,
  input  logic              phase,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [LANE_W-1:0] data_in,
  input  logic              ret_clk,
  input  logic              ret_data,
  output logic              scan_dout,
  output logic [LANE_W-1:0] out_byte
);
  logic [SEL_W-1:0]      sel_q, sel_d;
  logic [LANE_W-1:0]     byte_q, byte_d;
  logic [LANE_W-1:0]     cap_q, cap_d;
  logic [LANE_W-1:0]     out_q, out_d;
  logic [SEL_W-1:0]      slot;
  logic [LANE_IDX_W-1:0] lane;
  logic                  hit;

  assign slot = SEL_W'(pos >> LANE_IDX_W);
  assign lane = pos[LANE_IDX_W-1:0];
  assign hit  = (slot == sel_q);

  always_comb begin
    sel_d  = sel_q;
    byte_d = byte_q;
    cap_d  = cap_q;
    out_d  = out_q;
    if (state == ST_IDLE) begin
      sel_d  = sel_in;
      byte_d = data_in;
      cap_d  = '0;
    end
    // Take the chain's last bit on the edge where the shift clock rises.
    if (state == ST_DRAIN && !phase && !ret_clk && hit) cap_d[lane] = ret_data;
    if (state == ST_DRAIN && phase && pos == '0) out_d = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      byte_q <= '0;
      cap_q  <= '0;
      out_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      byte_q <= byte_d;
      cap_q  <= cap_d;
      out_q  <= out_d;
    end
  end

  assign scan_dout = (state == ST_LOAD) && hit && byte_q[lane];
  assign out_byte  = out_q;
endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_chain_pkg::*;
#(
  parameter int NUM_SLOTS    = 500,
  parameter int SEL_W        = 9,
  parameter int DEFAULT_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        drv_sel,
  input  logic [SEL_W-1:0]  sel_slot,
  input  logic [LANE_W-1:0] in_byte,
  input  logic              ret_clk,
  input  logic              ret_data,
  output logic              scan_clk,
  output logic              scan_dout,
  output logic              scan_sel,
  output logic              scan_latch,
  output logic              ready,
  output logic [LANE_W-1:0] out_byte
);
  localparam int CNT_W = $clog2(LANE_W * NUM_SLOTS);
  localparam logic [LANE_W-1:0] WAIT_DEF = LANE_W'(DEFAULT_WAIT);

  logic              rst_s_n;
  logic              load_win;
  logic [LANE_W-1:0] wait_q, wait_d;
  scan_state_e       state;
  logic [CNT_W-1:0]  pos;
  logic              phase;

  scan_chain_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n),
    .load_win   (load_win)
  );

  always_comb begin
    wait_d = wait_q;
    if (load_win && drv_sel == 2'b11) wait_d = in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= WAIT_DEF;
    else        wait_q <= wait_d;
  end

  scan_chain_fsm #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wait_len (wait_q),
    .state    (state),
    .pos      (pos),
    .phase    (phase)
  );

  scan_chain_bytepath #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .state     (state),
    .pos       (pos),
    .phase     (phase),
    .sel_in    (sel_slot),
    .data_in   (in_byte),
    .ret_clk   (ret_clk),
    .ret_data  (ret_data),
    .scan_dout (scan_dout),
    .out_byte  (out_byte)
  );

  assign scan_clk   = phase && (state == ST_LOAD || state == ST_GRAB || state == ST_DRAIN);
  assign scan_sel   = (state == ST_GRAB);
  assign scan_latch = (state == ST_STROBE);
  assign ready      = (state == ST_DONE);
endmodule

// File: rtl/scan_chain_ctrl_chk.sv
module scan_chain_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_clk,
  input logic       scan_sel,
  input logic       scan_latch,
  input logic       ready,
  input logic [7:0] out_byte
);
  assert_clk_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_clk |=> !scan_clk);

  assert_grab_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_sel) |-> !scan_clk);

  assert_grab_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_sel) |-> (!scan_clk && $past(scan_clk)));

  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte != $past(out_byte)) |-> ready);

  assert_latch_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scan_latch |-> (!scan_clk && !scan_sel));

  assert_latch_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scan_latch |=> !scan_latch);
endmodule

bind scan_chain_ctrl scan_chain_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_clk   (scan_clk),
  .scan_sel   (scan_sel),
  .scan_latch (scan_latch),
  .ready      (ready),
  .out_byte   (out_byte)
);

// File: tb/scan_chain_ctrl_bench.sv
module scan_chain_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 6;
  localparam int SELW       = 9;
  localparam int DEF_W      = 4;
  localparam int NBITS      = 8 * NSLOT;
  localparam int BASE_PER   = 32 * NSLOT + 5;

  function automatic logic [7:0] slot_resp(input int k, input logic [7:0] v);
    return v ^ 8'(195 + k * 29);
  endfunction

  function automatic logic [7:0] exp_out(input int s, input logic [7:0] v);
    return (s < NSLOT) ? slot_resp(s, v) : 8'h00;
  endfunction

  // {slot, input byte, expected out_byte}
  localparam logic [24:0] VEC [10] = '{
    {9'd0,   8'h00, exp_out(0, 8'h00)},
    {9'd0,   8'hFF, exp_out(0, 8'hFF)},
    {9'd5,   8'h3C, exp_out(5, 8'h3C)},
    {9'd2,   8'h02, exp_out(2, 8'h02)},
    {9'd3,   8'hA5, exp_out(3, 8'hA5)},
    {9'd1,   8'h81, exp_out(1, 8'h81)},
    {9'd4,   8'h7E, exp_out(4, 8'h7E)},
    {9'd7,   8'h55, exp_out(7, 8'h55)},
    {9'd511, 8'hFF, exp_out(511, 8'hFF)},
    {9'd5,   8'h01, exp_out(5, 8'h01)}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      drv_sel = 2'b00;
  logic [SELW-1:0] sel_slot = '0;
  logic [7:0]      in_byte = 8'h00;
  logic            force_rc = 1'b0;
  logic            ret_clk, ret_data;
  logic            scan_clk, scan_dout, scan_sel, scan_latch, ready;
  logic [7:0]      out_byte;

  logic [NBITS-1:0] ch = '0;
  logic [7:0]       din [NSLOT] = '{default: 8'h00};

  int n_checks = 0;
  int n_err    = 0;
  int cyc, hi_shift, hi_grab, latch_cyc, sel_cyc;

  scan_chain_ctrl #(
    .NUM_SLOTS(NSLOT), .SEL_W(SELW), .DEFAULT_WAIT(DEF_W)
  ) u_scan_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .drv_sel(drv_sel), .sel_slot(sel_slot),
    .in_byte(in_byte), .ret_clk(ret_clk), .ret_data(ret_data),
    .scan_clk(scan_clk), .scan_dout(scan_dout), .scan_sel(scan_sel),
    .scan_latch(scan_latch), .ready(ready), .out_byte(out_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Chain model: cell 0 is next to scan_dout; the last cell drives ret_data.
  always @(posedge scan_clk) begin
    if (scan_sel) begin
      for (int k = 0; k < NSLOT; k++) ch[8*k +: 8] <= slot_resp(k, din[k]);
    end else begin
      ch <= {ch[NBITS-2:0], scan_dout};
    end
  end

  always @(posedge scan_latch) begin
    for (int k = 0; k < NSLOT; k++) din[k] <= ch[8*k +: 8];
  end

  assign ret_data = ch[NBITS-1];
  assign ret_clk  = scan_clk | force_rc;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    cyc = 0; hi_shift = 0; hi_grab = 0; latch_cyc = 0; sel_cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (scan_clk && !scan_sel) hi_shift++;
      if (scan_clk && scan_sel)  hi_grab++;
      if (scan_latch)            latch_cyc++;
      if (scan_sel)              sel_cyc++;
    end while (!ready);
  endtask

  task automatic do_reset(input logic [1:0] ds, input logic [7:0] v);
    @(negedge clk);
    rst_n = 1'b0; drv_sel = ds; in_byte = v; sel_slot = '0;
    repeat (3) @(negedge clk);
    check("R1", {scan_clk, scan_dout, scan_sel, scan_latch, ready}, 0, "scan lines in reset");
    check("R1", out_byte, 0, "out_byte in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drv_sel = 2'b00;
  endtask

  task automatic measure_period(input string req, input int w);
    wait_ready();
    wait_ready();
    check(req, cyc, BASE_PER + w, "refresh period");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL R6 watchdog: actual hung expected refresh completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    do_reset(2'b00, 8'h00);
    wait_ready();

    // Vector table
    for (int i = 0; i < 10; i++) begin
      int s;
      logic [7:0] v, e;
      int bad;
      s = int'(VEC[i][24:16]);
      v = VEC[i][15:8];
      e = VEC[i][7:0];
      sel_slot = VEC[i][24:16];
      in_byte  = v;
      wait_ready();
      check((s < NSLOT) ? "R5" : "R10", out_byte, e, $sformatf("out_byte vec %0d", i));
      bad = 0;
      for (int k = 0; k < NSLOT; k++)
        if (din[k] !== ((k == s) ? v : 8'h00)) bad++;
      check((s < NSLOT) ? "R3" : "R10", bad, 0, $sformatf("slots with wrong latched byte vec %0d", i));
      check("R2", hi_shift, 16 * NSLOT, "shift clock high cycles");
      check("R4", hi_grab, 1, "capture clock edges");
      check("R4", sel_cyc, 2, "scan_sel cycles");
      check("R12", latch_cyc, 1, "latch cycles");
      check("R6", cyc, BASE_PER + DEF_W, "refresh period");
    end

    // R9: change inputs in the middle of a refresh
    sel_slot = 9'd2; in_byte = 8'h11;
    repeat (40) @(negedge clk);
    sel_slot = 9'd4; in_byte = 8'h99;
    wait_ready();
    check("R9", out_byte, exp_out(2, 8'h11), "result of refresh with mid-run change");
    wait_ready();
    check("R9", out_byte, exp_out(4, 8'h99), "following refresh");

    // R11: returned clock held high blocks capture
    force_rc = 1'b1; sel_slot = 9'd3; in_byte = 8'h5A;
    wait_ready();
    check("R11", out_byte, 0, "out_byte with ret_clk high");
    force_rc = 1'b0;
    wait_ready();
    check("R11", out_byte, exp_out(3, 8'h5A), "out_byte with ret_clk toggling");

    // R7 / R8: settle count at reset
    do_reset(2'b01, 8'd9);
    measure_period("R7", DEF_W);
    do_reset(2'b10, 8'd9);
    measure_period("R7", DEF_W);
    do_reset(2'b11, 8'd0);
    measure_period("R8", 0);
    sel_slot = 9'd1; in_byte = 8'hC6;
    wait_ready();
    check("R8", out_byte, exp_out(1, 8'hC6), "out_byte with zero settle");
    do_reset(2'b11, 8'd9);
    measure_period("R8", 9);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule